// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block watches a shared 16-bit free-running count that arrives from a separate counter block. It holds five compare channels, each with its own 16-bit compare value. When the count advances onto or past a channel's value, that channel's flag is raised. One 8-bit flag register holds the five compare flags and three capture flags. The capture flags are set by pulses from external capture logic. An 8-bit enable register has the same layout, and the block drives one interrupt request line that combines all enabled flags.

Software reaches the block through a write-only byte port. Each compare value is loaded one byte at a time. Flags are cleared by writing ones to them. The enable register is loaded with a single byte write. Detection is step based: the block remembers the count from the previous cycle and checks whether each compare value lies in the half-open window that the count just crossed. This catches matches when the count wraps and when it moves by more than one in a cycle. A count that sits still on a compare value does not set the flag again.

Top module: `ocmp_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears every compare value to 0x0000, every flag, every enable bit and the remembered count, so after reset `flag_o` reads 0x00 and `irq_o` is low.
- R2: A write to address 2*(c-1) loads the high byte of channel c's compare value, and a write to address 2*(c-1)+1 loads its low byte (c = 1..5). The other byte of that value keeps its previous contents.
- R3: Compare channel c sets flag bit 8-c, so channel 1 sets bit 7 and channel 5 sets bit 3. Capture input bits 2, 1 and 0 (capture channels 1, 2 and 3) set flag bits 2, 1 and 0. A flag bit only rises because of one of these sources.
- R4: When the count moves from value P to value N in one cycle, and a channel's compare value V lies in the window (P, N] taken modulo 65536, that channel's flag is set at that edge. This includes the step from 0xFFFF to 0x0000.
- R5: A cycle in which the count does not change sets no compare flag, even if the count equals a compare value, so a cleared flag stays clear while the count is held.
- R6: Writing to address 10 clears each flag bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: Writing to address 11 loads the enable register. `irq_o` is high exactly when some flag bit and the enable bit at the same position are both 1.
- R8: In a cycle that writes either byte of a channel's compare value, that channel detects no match. In a cycle that writes the enable register, no compare channel detects a match.
- R9: Writes to addresses 12 to 15 have no effect on flags, enables or compare values.
- R10: A step of more than one count sets the flag of every channel whose value lies in the crossed window (P, N].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Free-running count from the counter block |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 4 | Write address (0-9 compare bytes, 10 flag clear, 11 enable) |
| wr_data_i | input | 8 | Write data byte |
| cap_set_i | input | 3 | One-cycle pulses from capture logic, bit 2 = capture channel 1 |
| flag_o | output | 8 | Flag register contents |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the count only moves forward, modulo 65536, from one cycle to the next. A backward jump opens a window that covers almost the whole count range and would flag nearly every channel. The assertions also assume that capture pulses are well-formed single-cycle strobes. The stimulus keeps to these assumptions. It holds the count still while compare values are loaded. It only moves the count forward, in single steps, multi-count jumps and one wrap. Before any sequence that would need the count to go backwards, it applies reset.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int CNT_W   = 16;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int NUM_CMP = 5;
    localparam int NUM_CAP = 3;
    localparam int CHAN_W  = 3;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CMP,
        ACC_FLAG_CLR,
        ACC_ENABLE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [CHAN_W-1:0]  chan;
        logic               hi_byte;
    } acc_dec_t;

    // Address map: compare bytes first (high then low per channel),
    // then flag clear, then enable; anything above is unused.
    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_cmp);
        acc_dec_t d;
        d.kind    = ACC_NONE;
        d.chan    = '0;
        d.hi_byte = 1'b0;
        if (32'(a) < 2 * n_cmp) begin
            d.kind    = ACC_CMP;
            d.chan    = CHAN_W'(a >> 1);
            d.hi_byte = ~a[0];
        end else if (32'(a) == 2 * n_cmp) begin
            d.kind = ACC_FLAG_CLR;
        end else if (32'(a) == 2 * n_cmp + 1) begin
            d.kind = ACC_ENABLE;
        end
        return d;
    endfunction

    // Flag position of compare channel index c (0-based): top bits first.
    function automatic int cmp_flag_pos(input int c, input int flag_w);
        return flag_w - 1 - c;
    endfunction

endpackage

// File: rtl/ocmp_cmp_regs.sv
module ocmp_cmp_regs
    import ocmp_pkg::*;
#(
    parameter int N_CMP = NUM_CMP,
    parameter int CW    = CNT_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int FW    = NUM_CMP + NUM_CAP
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [N_CMP-1:0][CW-1:0]  cmp_o,
    output logic [N_CMP-1:0]          rearm_o,
    output logic [FW-1:0]             clr_mask_o,
    output logic                      ena_wr_o,
    output logic [FW-1:0]             ena_data_o
);

    localparam int HI_LSB = CW - DW;

    acc_dec_t dec;
    logic [N_CMP-1:0][CW-1:0] cmp_q;

    always_comb begin
        dec = decode_addr(wr_addr_i, N_CMP);
    end

    assign ena_wr_o   = wr_en_i && (dec.kind == ACC_ENABLE);
    assign ena_data_o = FW'(wr_data_i);
    assign clr_mask_o = (wr_en_i && (dec.kind == ACC_FLAG_CLR)) ? FW'(wr_data_i) : '0;

    for (genvar c = 0; c < N_CMP; c++) begin : g_chan
        logic hit_this;
        assign hit_this = wr_en_i && (dec.kind == ACC_CMP) && (dec.chan == CHAN_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[c] <= '0;
            end else if (hit_this) begin
                if (dec.hi_byte) begin
                    cmp_q[c][CW-1:HI_LSB] <= wr_data_i;
                end else begin
                    cmp_q[c][DW-1:0] <= wr_data_i;
                end
            end
        end

        assign rearm_o[c] = hit_this || ena_wr_o;
    end

    assign cmp_o = cmp_q;

    // Compare values only move on a byte write (R2).
    assert_cmp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(cmp_q));

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
    parameter int CW = ocmp_pkg::CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  cnt_i,
    input  logic [CW-1:0]  prev_i,
    input  logic           prev_valid_i,
    input  logic [CW-1:0]  cmp_i,
    input  logic           rearm_i,
    output logic           hit_o
);

    logic [CW-1:0] dist_cmp;
    logic [CW-1:0] dist_step;

    // Window (prev, cnt] modulo 2^CW: the compare value lies inside when
    // its distance back from cnt is shorter than the step just taken.
    assign dist_cmp  = cnt_i - cmp_i;
    assign dist_step = cnt_i - prev_i;
    assign hit_o     = prev_valid_i && !rearm_i && (dist_cmp < dist_step);

    // A match needs a count step (R5).
    assert_step_needed_R5: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (cnt_i != prev_i));

endmodule

// File: rtl/ocmp_flags.sv
module ocmp_flags #(
    parameter int FW = ocmp_pkg::NUM_CMP + ocmp_pkg::NUM_CAP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [FW-1:0]  set_vec_i,
    input  logic [FW-1:0]  clr_mask_i,
    input  logic           ena_wr_i,
    input  logic [FW-1:0]  ena_data_i,
    output logic [FW-1:0]  flag_o,
    output logic           irq_o
);

    logic [FW-1:0] flag_q;
    logic [FW-1:0] ena_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            ena_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask_i) | set_vec_i;
            if (ena_wr_i) begin
                ena_q <= ena_data_i;
            end
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & ena_q);

    // Every set request lands, even against a clear (R4, R6).
    assert_set_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (set_vec_i != '0) |=> ((flag_q & $past(set_vec_i)) == $past(set_vec_i)));

    // With no clear and no set, flags hold (R6).
    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_mask_i == '0 && set_vec_i == '0) |=> (flag_q == $past(flag_q)));

    // No flag rises without a source (R3).
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_q & ~$past(flag_q) & ~$past(set_vec_i)) == '0);

    // The request only drops after a clear or an enable write (R7).
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(clr_mask_i != '0 || ena_wr_i));

endmodule

// File: rtl/ocmp_top.sv
module ocmp_top
    import ocmp_pkg::*;
#(
    parameter int N_CMP = NUM_CMP,
    parameter int N_CAP = NUM_CAP,
    parameter int CW    = CNT_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CW-1:0]           cnt_i,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           wr_addr_i,
    input  logic [DW-1:0]           wr_data_i,
    input  logic [N_CAP-1:0]        cap_set_i,
    output logic [N_CMP+N_CAP-1:0]  flag_o,
    output logic                    irq_o
);

    localparam int FW = N_CMP + N_CAP;

    logic [CW-1:0]             prev_q;
    logic                      prev_valid_q;
    logic [N_CMP-1:0][CW-1:0]  cmp;
    logic [N_CMP-1:0]          rearm;
    logic [N_CMP-1:0]          hit;
    logic [FW-1:0]             clr_mask;
    logic                      ena_wr;
    logic [FW-1:0]             ena_data;
    logic [FW-1:0]             set_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q       <= '0;
            prev_valid_q <= 1'b0;
        end else begin
            prev_q       <= cnt_i;
            prev_valid_q <= 1'b1;
        end
    end

    ocmp_cmp_regs #(
        .N_CMP (N_CMP),
        .CW    (CW),
        .DW    (DW),
        .AW    (AW),
        .FW    (FW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cmp_o      (cmp),
        .rearm_o    (rearm),
        .clr_mask_o (clr_mask),
        .ena_wr_o   (ena_wr),
        .ena_data_o (ena_data)
    );

    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        ocmp_channel #(.CW(CW)) u_chan (
            .clk          (clk),
            .rst          (rst),
            .cnt_i        (cnt_i),
            .prev_i       (prev_q),
            .prev_valid_i (prev_valid_q),
            .cmp_i        (cmp[c]),
            .rearm_i      (rearm[c]),
            .hit_o        (hit[c])
        );
        assign set_vec[cmp_flag_pos(c, FW)] = hit[c];
    end

    assign set_vec[N_CAP-1:0] = cap_set_i;

    ocmp_flags #(.FW(FW)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_vec_i  (set_vec),
        .clr_mask_i (clr_mask),
        .ena_wr_i   (ena_wr),
        .ena_data_i (ena_data),
        .flag_o     (flag_o),
        .irq_o      (irq_o)
    );

    // A written channel detects nothing on the write edge (R8).
    assert_rearm_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ((rearm & hit) == '0));

endmodule

// File: tb/sim_ocmp_top.sv
module sim_ocmp_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  cap = '0;
    logic [7:0]  flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ocmp_top u0 (
        .clk       (clk),
        .rst       (rst),
        .cnt_i     (cnt),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .cap_set_i (cap),
        .flag_o    (flag),
        .irq_o     (irq)
    );

    // {count to step to, expected flags afterwards}
    localparam logic [23:0] VECS [10] = '{
        {16'h000F, 8'h00}, {16'h0010, 8'h80}, {16'h0011, 8'h80},
        {16'h001F, 8'h80}, {16'h0022, 8'hC0}, {16'h0100, 8'hC0},
        {16'h0106, 8'hC8}, {16'hFFFE, 8'hC8}, {16'hFFFF, 8'hE8},
        {16'h0000, 8'hF8}
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One clock edge with the given stimulus; returns at the next falling edge.
    task automatic cyc(input logic we, input logic [3:0] a, input logic [7:0] d,
                       input logic [15:0] c, input logic [2:0] cs);
        wr_en = we; wr_addr = a; wr_data = d; cnt = c; cap = cs;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cap = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, cnt, 3'b000);
    endtask

    task automatic step(input logic [15:0] c);
        cyc(1'b0, 4'd0, 8'd0, c, 3'b000);
    endtask

    task automatic do_reset();
        rst = 1'b1; cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk8("R1 flags after reset", flag, 8'h00);
        chk1("R1 irq after reset", irq, 1'b0);

        // Compare values: ch1 0x0010, ch2 0x0020, ch3 0xFFFF, ch4 0x0000, ch5 0x0105
        wr(4'd1, 8'h10);
        wr(4'd3, 8'h20);
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
        wr(4'd8, 8'h01); wr(4'd9, 8'h05);
        wr(4'd11, 8'hF8);
        chk8("R5 held count during setup", flag, 8'h00);

        // Vector walk: R3 positions, R4 window and wrap, R10 multi-step
        for (int i = 0; i < 10; i++) begin
            step(VECS[i][23:8]);
            chk8($sformatf("R4 R10 R3 vector %0d", i), flag, VECS[i][7:0]);
        end
        chk1("R7 irq with enabled flags", irq, 1'b1);

        // R6 write-one-to-clear
        wr(4'd10, 8'h80);
        chk8("R6 clear bit 7", flag, 8'h78);
        wr(4'd10, 8'h00);
        chk8("R6 zero write keeps flags", flag, 8'h78);

        // R5 steady count on ch4 value 0x0000
        wr(4'd10, 8'h10);
        step(16'h0000); step(16'h0000); step(16'h0000);
        chk8("R5 steady match stays clear", flag, 8'h68);

        // R7 gating and R3 capture positions
        wr(4'd10, 8'hFF);
        chk8("R6 clear all", flag, 8'h00);
        chk1("R7 irq low after clear", irq, 1'b0);
        wr(4'd11, 8'h00);
        cyc(1'b0, 4'd0, 8'h00, cnt, 3'b100);
        chk8("R3 capture 1 at bit 2", flag, 8'h04);
        chk1("R7 masked flag no irq", irq, 1'b0);
        wr(4'd11, 8'h04);
        chk1("R7 enable raises irq", irq, 1'b1);

        // R6 set wins over clear
        cyc(1'b1, 4'd10, 8'h01, cnt, 3'b001);
        chk8("R6 set beats clear", flag, 8'h05);
        wr(4'd10, 8'h01);
        chk8("R6 clear bit 0", flag, 8'h04);

        // R2 byte writes keep the other byte
        wr(4'd10, 8'hFF);
        wr(4'd1, 8'h40);
        wr(4'd9, 8'h30);
        wr(4'd2, 8'h01);
        step(16'h0010);
        chk8("R2 old ch1 low byte replaced", flag, 8'h00);
        step(16'h0030);
        chk8("R2 ch5 high byte kept", flag, 8'h00);
        step(16'h0040);
        chk8("R2 ch1 new low byte", flag, 8'h80);
        step(16'h0120);
        chk8("R2 ch2 new high byte, low kept", flag, 8'hC0);
        step(16'h0130);
        chk8("R2 ch5 combined value", flag, 8'hC8);
        chk1("R7 disabled flags no irq", irq, 1'b0);

        // R9 unused addresses
        for (int a = 12; a < 16; a++) wr(4'(a), 8'hFF);
        chk8("R9 unused addresses keep flags", flag, 8'hC8);
        chk1("R9 unused addresses keep enables", irq, 1'b0);

        // R1 mid-run reset
        do_reset();
        chk8("R1 flags after second reset", flag, 8'h00);
        chk1("R1 irq after second reset", irq, 1'b0);

        // R8 re-arm on compare write
        wr(4'd3, 8'h05);
        cyc(1'b1, 4'd2, 8'h00, 16'h0005, 3'b000);
        chk8("R8 write edge suppresses ch2", flag, 8'h00);
        step(16'h0006);
        chk8("R8 past value not caught later", flag, 8'h00);
        wr(4'd1, 8'h07);
        step(16'h0007);
        chk8("R4 ch1 after reset", flag, 8'h80);

        // R8 re-arm on enable write
        wr(4'd5, 8'h09);
        cyc(1'b1, 4'd11, 8'h00, 16'h0009, 3'b000);
        chk8("R8 enable write suppresses ch3", flag, 8'h80);
        step(16'h000A);
        chk8("R8 no late flag", flag, 8'h80);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule